// File: doc/BRIEF.md
# Bitmap-Indexed Variable-Length Value Store

This block holds values of varying size by slicing each value into fixed 16-byte chunks and placing them in a row of parallel chunk arrays. A small key table turns an incoming key into three things: a hit flag, a bitmap that names the arrays the key occupies, and one slot index. Every array whose bitmap bit is set is accessed at that single slot, and all arrays are accessed in the same cycle. No loop runs over the arrays.

On a read, the chunks from the selected arrays are packed together, lowest array first, with no gaps, and returned with a byte length. On an update, the incoming value is unpacked the same way: its first chunk goes to the lowest selected array, the next chunk to the next selected array, and so on. Two keys may use the same slot index if their bitmaps do not overlap. The key table stands in for the real key match and allocation logic, and it is loaded through a config port.

Top module: `vs_value_store`

## Requirements
- R1: After synchronous active-low reset, `rsp_valid` is low and every key table entry is invalid, so any key misses.
- R2: A config write stores key, bitmap and index in the chosen entry. A request in the same cycle as the write still sees the old mapping. Requests in later cycles see the new one.
- R3: Each request produces exactly one one-cycle `rsp_valid` pulse, two rising edges after the request is sampled.
- R4: A read hit returns the chunks of the selected arrays packed in ascending array order. The lowest selected array goes in `rsp_value[127:0]`, the next in `[255:128]`, and so on. All chunks above the packed ones are zero.
- R5: On a hit, `rsp_len` equals 16 times the number of set bitmap bits. For an 8'hFF bitmap this is 128.
- R6: An update hit writes chunk k of `req_wdata` (bits 128k+127 to 128k) into the k-th selected array at the slot index. Chunks at k equal to or above the popcount are ignored. Unselected arrays keep their contents.
- R7: Two keys at the same index with disjoint bitmaps (for example b and ~b) keep their values apart, whatever order they are written in.
- R8: An update response has `rsp_hit`=1, `rsp_op`=1 and `rsp_len` as in R5, and `rsp_value` is all zero.
- R9: A request whose key is in no valid entry responds with `rsp_hit`=0, `rsp_len`=0 and an all-zero `rsp_value`.
- R10: A read issued in the cycle right after an update of the same key returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write one key table entry |
| cfg_entry | input | 3 | Entry number to write |
| cfg_valid | input | 1 | Valid flag for the written entry |
| cfg_key | input | 128 | Key stored in the entry |
| cfg_bitmap | input | 8 | Array selection for the key |
| cfg_index | input | 4 | Slot index for the key |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 1 | 0 = read, 1 = update |
| req_key | input | 128 | Key to look up |
| req_wdata | input | 1024 | Packed update value, chunk 0 in the low bits |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | Key was found |
| rsp_op | output | 1 | Operation of the answered request |
| rsp_value | output | 1024 | Packed read value |
| rsp_len | output | 8 | Value length in bytes |

## Verification
Two functions can land in the same cycle, and the bench provokes both. First, a config write and a read of the same key are driven together, and the read must return the length and data of the old mapping. Second, an update sits in the array stage while the next request, a read of that key, is being looked up, and that read must return the fresh data. Around these, an exhaustive sweep covers all 256 bitmaps. Each bitmap is paired with its complement at one shared index, so every packing pattern and every neighbour isolation case is compared with chunk patterns that the bench computes.

// File: rtl/vs_pkg.sv
`timescale 1ns/1ps
// Shared types for the variable-length value store.
package vs_pkg;
    typedef enum logic {
        VS_READ   = 1'b0,
        VS_UPDATE = 1'b1
    } vs_op_e;
endpackage

// File: rtl/vs_key_table.sv
`timescale 1ns/1ps
// Key table: maps a key to (hit, bitmap, slot index).
// Assumes entries are loaded through the config port. The lookup is
// combinational and gives priority to the lowest-numbered matching entry.
module vs_key_table #(
    parameter int KEY_W   = 128,
    parameter int ENTRIES = 8,
    parameter int NUM_ARR = 8,
    parameter int IDX_W   = 4,
    localparam int ENT_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [ENT_W-1:0]   cfg_entry,
    input  logic               cfg_valid,
    input  logic [KEY_W-1:0]   cfg_key,
    input  logic [NUM_ARR-1:0] cfg_bitmap,
    input  logic [IDX_W-1:0]   cfg_index,
    input  logic [KEY_W-1:0]   lk_key,
    output logic               lk_hit,
    output logic [NUM_ARR-1:0] lk_bitmap,
    output logic [IDX_W-1:0]   lk_index
);
    logic [ENTRIES-1:0] tbl_valid;
    logic [KEY_W-1:0]   tbl_key    [ENTRIES];
    logic [NUM_ARR-1:0] tbl_bitmap [ENTRIES];
    logic [IDX_W-1:0]   tbl_index  [ENTRIES];

    // Valid flags: cleared by reset, set or cleared by config writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tbl_valid <= '0;
        else if (cfg_we)
            tbl_valid[cfg_entry] <= cfg_valid;
    end

    // Entry payload: needs no reset because the valid flag guards it.
    always_ff @(posedge clk) begin
        if (cfg_we) begin
            tbl_key[cfg_entry]    <= cfg_key;
            tbl_bitmap[cfg_entry] <= cfg_bitmap;
            tbl_index[cfg_entry]  <= cfg_index;
        end
    end

    // Search: scans downward so the lowest matching entry wins.
    always_comb begin
        lk_hit    = 1'b0;
        lk_bitmap = '0;
        lk_index  = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (tbl_valid[e] && tbl_key[e] == lk_key) begin
                lk_hit    = 1'b1;
                lk_bitmap = tbl_bitmap[e];
                lk_index  = tbl_index[e];
            end
        end
    end

    // R2: a config write is visible in the entry one edge later.
    assert_cfg_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (tbl_valid[$past(cfg_entry)] == $past(cfg_valid)));
endmodule

// File: rtl/vs_chunk_array.sv
`timescale 1ns/1ps
// One chunk array: a single-port memory with a registered read.
// When enabled it reads the slot and, if we is set, also writes it.
// The read returns the old contents. rdata holds when not enabled.
module vs_chunk_array #(
    parameter int CHUNK_W = 128,
    parameter int DEPTH   = 16,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               en,
    input  logic               we,
    input  logic [IDX_W-1:0]   addr,
    input  logic [CHUNK_W-1:0] wdata,
    output logic [CHUNK_W-1:0] rdata
);
    logic [CHUNK_W-1:0] mem [DEPTH];

    // Access: one slot per cycle, write and registered read together.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we)
                mem[addr] <= wdata;
            rdata <= mem[addr];
        end
    end
endmodule

// File: rtl/vs_lane_map.sv
`timescale 1ns/1ps
// Lane map between a packed value and the per-array lanes.
// The chunk position of array i is the number of set bitmap bits below i.
// GATHER=1 packs lanes into a gap-free value. GATHER=0 spreads a packed
// value onto the selected lanes. count returns the popcount of the bitmap.
module vs_lane_map #(
    parameter int NUM_ARR = 8,
    parameter int CHUNK_W = 128,
    parameter bit GATHER  = 1'b1,
    localparam int CNT_W  = $clog2(NUM_ARR + 1),
    localparam int VAL_W  = NUM_ARR * CHUNK_W
) (
    input  logic [NUM_ARR-1:0] bitmap,
    input  logic [VAL_W-1:0]   din,
    output logic [VAL_W-1:0]   dout,
    output logic [CNT_W-1:0]   count
);
    logic [CNT_W-1:0] pos [NUM_ARR];

    // Prefix count: the packed position of each array.
    always_comb begin
        logic [CNT_W-1:0] run;
        run = '0;
        for (int i = 0; i < NUM_ARR; i++) begin
            pos[i] = run;
            run    = run + CNT_W'(bitmap[i]);
        end
        count = run;
    end

    generate
        if (GATHER) begin : g_gather
            // Gather: each selected lane lands at its packed position.
            always_comb begin
                dout = '0;
                for (int i = 0; i < NUM_ARR; i++)
                    if (bitmap[i])
                        dout[pos[i]*CHUNK_W +: CHUNK_W] = din[i*CHUNK_W +: CHUNK_W];
            end
        end else begin : g_scatter
            // Scatter: each selected lane takes the chunk at its position.
            always_comb begin
                dout = '0;
                for (int i = 0; i < NUM_ARR; i++)
                    if (bitmap[i])
                        dout[i*CHUNK_W +: CHUNK_W] = din[pos[i]*CHUNK_W +: CHUNK_W];
            end
        end
    endgenerate
endmodule

// File: rtl/vs_value_store.sv
`timescale 1ns/1ps
// Variable-length value store. The pipeline has three parts:
//   lookup (comb) -> stage 1 register -> array access -> response register.
// Every selected array uses the same slot index. Values are packed
// gap-free in ascending array order. A response follows its request by
// two edges. Assumes the config port does not rewrite an entry that a
// request is still using while that request is in flight.
module vs_value_store
    import vs_pkg::*;
#(
    parameter int KEY_W   = 128,
    parameter int NUM_ARR = 8,
    parameter int CHUNK_W = 128,
    parameter int DEPTH   = 16,
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int ENT_W  = $clog2(ENTRIES),
    localparam int VAL_W  = NUM_ARR * CHUNK_W,
    localparam int CNT_W  = $clog2(NUM_ARR + 1),
    localparam int LEN_W  = $clog2(VAL_W / 8 + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [ENT_W-1:0]   cfg_entry,
    input  logic               cfg_valid,
    input  logic [KEY_W-1:0]   cfg_key,
    input  logic [NUM_ARR-1:0] cfg_bitmap,
    input  logic [IDX_W-1:0]   cfg_index,
    input  logic               req_valid,
    input  logic               req_op,
    input  logic [KEY_W-1:0]   req_key,
    input  logic [VAL_W-1:0]   req_wdata,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic               rsp_op,
    output logic [VAL_W-1:0]   rsp_value,
    output logic [LEN_W-1:0]   rsp_len
);
    logic               lk_hit;
    logic [NUM_ARR-1:0] lk_bitmap;
    logic [IDX_W-1:0]   lk_index;

    logic               s1_valid, s1_hit;
    vs_op_e             s1_op;
    logic [NUM_ARR-1:0] s1_bitmap;
    logic [IDX_W-1:0]   s1_index;
    logic [VAL_W-1:0]   s1_wdata;

    logic [VAL_W-1:0]   lane_wdata, lane_rdata;
    logic [CNT_W-1:0]   wr_cnt, rd_cnt;
    logic [NUM_ARR-1:0] s2_bitmap;

    vs_key_table #(
        .KEY_W(KEY_W), .ENTRIES(ENTRIES), .NUM_ARR(NUM_ARR), .IDX_W(IDX_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_entry(cfg_entry), .cfg_valid(cfg_valid),
        .cfg_key(cfg_key), .cfg_bitmap(cfg_bitmap), .cfg_index(cfg_index),
        .lk_key(req_key), .lk_hit(lk_hit), .lk_bitmap(lk_bitmap), .lk_index(lk_index)
    );

    // Stage 1: capture the lookup result and the write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_hit    <= 1'b0;
            s1_op     <= VS_READ;
            s1_bitmap <= '0;
            s1_index  <= '0;
        end else begin
            s1_valid  <= req_valid;
            s1_hit    <= req_valid && lk_hit;
            s1_op     <= vs_op_e'(req_op);
            s1_bitmap <= lk_bitmap;
            s1_index  <= lk_index;
        end
    end

    // Write data register: needs no reset because s1_valid guards it.
    always_ff @(posedge clk) begin
        s1_wdata <= req_wdata;
    end

    vs_lane_map #(.NUM_ARR(NUM_ARR), .CHUNK_W(CHUNK_W), .GATHER(1'b0)) u_scatter (
        .bitmap(s1_bitmap), .din(s1_wdata), .dout(lane_wdata), .count(wr_cnt)
    );

    generate
        for (genvar i = 0; i < NUM_ARR; i++) begin : g_arr
            vs_chunk_array #(.CHUNK_W(CHUNK_W), .DEPTH(DEPTH)) u_arr (
                .clk  (clk),
                .en   (s1_valid && s1_hit && s1_bitmap[i]),
                .we   (s1_op == VS_UPDATE),
                .addr (s1_index),
                .wdata(lane_wdata[i*CHUNK_W +: CHUNK_W]),
                .rdata(lane_rdata[i*CHUNK_W +: CHUNK_W])
            );
        end
    endgenerate

    // Response stage: flags, length and the bitmap that the gather uses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_op    <= 1'b0;
            rsp_len   <= '0;
            s2_bitmap <= '0;
        end else begin
            rsp_valid <= s1_valid;
            rsp_hit   <= s1_hit;
            rsp_op    <= s1_op;
            rsp_len   <= s1_hit ? LEN_W'(wr_cnt) * LEN_W'(CHUNK_W / 8) : '0;
            s2_bitmap <= (s1_hit && s1_op == VS_READ) ? s1_bitmap : '0;
        end
    end

    vs_lane_map #(.NUM_ARR(NUM_ARR), .CHUNK_W(CHUNK_W), .GATHER(1'b1)) u_gather (
        .bitmap(s2_bitmap), .din(lane_rdata), .dout(rsp_value), .count(rd_cnt)
    );

    // R3: a response needs a request two edges earlier.
    assert_rsp_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid, 2));

    // R9: a miss carries no length and no data.
    assert_miss_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_len == '0 && rsp_value == '0));

    // R5: the read length agrees with the number of gathered chunks.
    assert_len_matches_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && !rsp_op) |-> (rsp_len == LEN_W'(rd_cnt) * LEN_W'(CHUNK_W / 8)));

    // R8: an update response returns no data.
    assert_update_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_op) |-> (rsp_value == '0));
endmodule

// File: tb/vs_value_store_bench.sv
`timescale 1ns/1ps
module vs_value_store_bench;
    localparam int NA = 8;
    localparam int CW = 128;
    localparam int VW = NA * CW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we, cfg_valid;
    logic [2:0]    cfg_entry;
    logic [127:0]  cfg_key;
    logic [7:0]    cfg_bitmap;
    logic [3:0]    cfg_index;
    logic          req_valid, req_op;
    logic [127:0]  req_key;
    logic [VW-1:0] req_wdata;
    logic          rsp_valid, rsp_hit, rsp_op;
    logic [VW-1:0] rsp_value;
    logic [7:0]    rsp_len;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    vs_value_store u_vs_value_store (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_entry(cfg_entry), .cfg_valid(cfg_valid),
        .cfg_key(cfg_key), .cfg_bitmap(cfg_bitmap), .cfg_index(cfg_index),
        .req_valid(req_valid), .req_op(req_op), .req_key(req_key), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_op(rsp_op),
        .rsp_value(rsp_value), .rsp_len(rsp_len)
    );

    always #2.5 clk = ~clk;

    // One chunk of a test value, unique per tag, sweep step and chunk number.
    function automatic logic [CW-1:0] chunk_of(input int tag, input int s, input int k);
        return {32'(tag), 32'(s), 32'(k), 32'hC0DE_0000 | 32'(tag * 16 + k)};
    endfunction

    // Full eight-chunk value; every chunk is non-zero.
    function automatic logic [VW-1:0] value_of(input int tag, input int s);
        logic [VW-1:0] v;
        for (int k = 0; k < NA; k++) v[k*CW +: CW] = chunk_of(tag, s, k);
        return v;
    endfunction

    // Expected read: the first popcount chunks of the written value, zero above.
    function automatic logic [VW-1:0] expect_read(input int tag, input int s, input logic [7:0] bm);
        logic [VW-1:0] v;
        v = '0;
        for (int k = 0; k < $countones(bm); k++) v[k*CW +: CW] = chunk_of(tag, s, k);
        return v;
    endfunction

    task automatic check(input string req, input logic e_hit, input logic e_op,
                         input logic [7:0] e_len, input logic [VW-1:0] e_val);
        tests++;
        if (rsp_valid !== 1'b1 || rsp_hit !== e_hit || rsp_op !== e_op ||
            rsp_len !== e_len || rsp_value !== e_val) begin
            fails++;
            $display("FAIL %s: valid=%b hit=%b op=%b len=%0d value=%h | expected valid=1 hit=%b op=%b len=%0d value=%h",
                     req, rsp_valid, rsp_hit, rsp_op, rsp_len, rsp_value, e_hit, e_op, e_len, e_val);
        end
    endtask

    task automatic check_idle(input string req);
        tests++;
        if (rsp_valid !== 1'b0) begin
            fails++;
            $display("FAIL %s: rsp_valid=%b expected 0", req, rsp_valid);
        end
    endtask

    task automatic cfg(input int e, input logic [127:0] k, input logic [7:0] bm, input logic [3:0] idx);
        @(negedge clk);
        cfg_we = 1'b1; cfg_entry = 3'(e); cfg_valid = 1'b1;
        cfg_key = k; cfg_bitmap = bm; cfg_index = idx;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Issue one request and wait until its response is visible (after edge 2).
    task automatic send(input logic op, input logic [127:0] k, input logic [VW-1:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_key = k; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_valid = 1'b0; cfg_entry = '0; cfg_key = '0;
        cfg_bitmap = '0; cfg_index = '0; req_valid = 1'b0; req_op = 1'b0;
        req_key = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 reset rsp_valid");

        // R1/R9: an empty table misses on every key.
        send(1'b0, 128'h5, '0);
        check("R1 R9 read miss after reset", 1'b0, 1'b0, 8'd0, '0);
        send(1'b1, 128'h77, value_of(9, 9));
        check("R9 update miss", 1'b0, 1'b1, 8'd0, '0);
        @(negedge clk);
        check_idle("R3 single response pulse");

        // R4 R5 R6 R7 R8: every bitmap b shares index b%16 with its complement.
        for (int b = 0; b < 256; b++) begin
            logic [7:0] bm_a, bm_b;
            logic [127:0] ka, kb;
            bm_a = 8'(b); bm_b = ~8'(b);
            ka = 128'hA000 + 128'(b); kb = 128'hB000 + 128'(b);
            cfg(0, ka, bm_a, 4'(b));
            cfg(1, kb, bm_b, 4'(b));
            send(1'b1, ka, value_of(1, b));
            check("R8 update A", 1'b1, 1'b1, 8'($countones(bm_a) * 16), '0);
            send(1'b1, kb, value_of(2, b));
            check("R8 update B", 1'b1, 1'b1, 8'($countones(bm_b) * 16), '0);
            send(1'b0, ka, '0);
            check("R4 R5 R6 R7 read A", 1'b1, 1'b0, 8'($countones(bm_a) * 16), expect_read(1, b, bm_a));
            send(1'b0, kb, '0);
            check("R4 R5 R6 R7 read B", 1'b1, 1'b0, 8'($countones(bm_b) * 16), expect_read(2, b, bm_b));
        end

        // R2: a config write and a read of the same key in one cycle use the old mapping.
        cfg(2, 128'hC2, 8'h03, 4'd7);
        send(1'b1, 128'hC2, value_of(3, 0));
        @(negedge clk);
        cfg_we = 1'b1; cfg_entry = 3'd2; cfg_valid = 1'b1; cfg_key = 128'hC2;
        cfg_bitmap = 8'h1C; cfg_index = 4'd7;
        req_valid = 1'b1; req_op = 1'b0; req_key = 128'hC2;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        check("R2 same-cycle config keeps old mapping", 1'b1, 1'b0, 8'd32, expect_read(3, 0, 8'h03));
        send(1'b1, 128'hC2, value_of(4, 0));
        check("R2 new mapping length on update", 1'b1, 1'b1, 8'd48, '0);
        send(1'b0, 128'hC2, '0);
        check("R2 new mapping read", 1'b1, 1'b0, 8'd48, expect_read(4, 0, 8'h1C));

        // R10: back-to-back update then read of the same key.
        cfg(3, 128'hD3, 8'hFF, 4'd9);
        @(negedge clk);
        req_valid = 1'b1; req_op = 1'b1; req_key = 128'hD3; req_wdata = value_of(5, 1);
        @(negedge clk);
        req_op = 1'b0; req_wdata = '0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 update response", 1'b1, 1'b1, 8'd128, '0);
        @(negedge clk);
        check("R10 R5 read right after update", 1'b1, 1'b0, 8'd128, value_of(5, 1));
        @(negedge clk);
        check_idle("R3 pipeline drained");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule